// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

The router lets any one of up to 256 general-purpose input pins drive each of eight interrupt lines. Every channel owns a pin selector, a mode bit that chooses edge or level detection, a sense bit that inverts what counts as active, and a glitch-filter length. The raw pins are synchronised into the clock domain first. Each channel then picks its pin, runs it through its filter and either latches an event or passes the level on. Because the inversion happens inside the block, every interrupt line is active-high whatever sense is programmed.

Software programs the router through a plain 32-bit word-addressed write/read port with a combinational read path. Latched edge events are acknowledged by writing ones to a status word. Bits written as zero there leave pending events in place.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every configuration word (addresses 0 to 3) and the status word (address 4) read as zero, and all interrupt lines are low.
- R2: Word 0 keeps the edge-select bit of channel n at bit n and the inverted-sense bit of channel n at bit 16+n. Its other bits read zero. Word 1 keeps the 4-bit filter length of channel n at bits 4n..4n+3. The 8-bit pin selector of channel n sits at word 2+(n/4), bits 8(n mod 4)..8(n mod 4)+7. All of these read back as written.
- R3: A channel reacts only to the pin its selector names, for every selector value from 0 to 255.
- R4: In level mode with sense bit 0, the line is high while the selected pin is high. With filter length 0, a change on the pin reaches the line on the fourth rising clock edge after it, and not before.
- R5: In level mode with sense bit 1, the line is high while the selected pin is low.
- R6: In edge mode with sense bit 0, a rising edge sets the line. The line then stays high after the pin falls.
- R7: In edge mode with sense bit 1, a falling edge sets the line and a rising edge does not.
- R8: Word 4 reads the pending edge events, bit n for channel n. Writing it clears the channels whose data bits are 1 and leaves the rest pending. If a new edge arrives in the same cycle as the clear, the event stays pending.
- R9: With filter length k > 0, the filtered value changes only after the pin has held a new value for k consecutive sample ticks, one tick every SAMPLE_DIV clocks. A pulse of at most (k-1)*SAMPLE_DIV clocks is ignored, and one of (k+1)*SAMPLE_DIV clocks is accepted.
- R10: Filter length 0 bypasses the filter, so a one-clock pulse registers as an edge.
- R11: Channels act independently: a pin routed to one channel raises only that channel's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Raw, unsynchronised pin levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_o | output | NUM_CH | Active-high interrupt line per channel |

## Verification
A wrong selector decode or a misplaced field appears at the ports in two ways. A sweep that drives one pin at a time shows the line rising for the wrong pin. A read-back shows bits moving out of place. Both appear within four clocks of the stimulus. A bad filter counter shows up as a short pulse that gets through or a held level that never does; either can be seen one sample period after the k-th tick. Broken sticky or clear logic in the pending register shows as a line that drops without a status write or survives one. That is visible on the very next clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 3;
  localparam int FILT_W    = 4;
  localparam int POL_SHIFT = 16;
  localparam int A_MODE    = 0;
  localparam int A_FILT    = 1;
  localparam int A_SEL0    = 2;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs import gpio_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  input  logic [NUM_CH-1:0]            pend_i,
  output logic [NUM_CH-1:0]            edge_o,
  output logic [NUM_CH-1:0]            pol_o,
  output logic [NUM_CH-1:0][FILT_W-1:0] filt_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]  sel_o,
  output logic [NUM_CH-1:0]            clr_o
);
  localparam int SEL_PER_WORD = REG_W / SEL_W;
  localparam int SEL_WORDS    = (NUM_CH + SEL_PER_WORD - 1) / SEL_PER_WORD;
  localparam int A_STAT       = A_SEL0 + SEL_WORDS;

  logic [NUM_CH-1:0]             edge_q, edge_d, pol_q, pol_d;
  logic [NUM_CH-1:0][FILT_W-1:0] filt_q, filt_d;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel_q, sel_d;
  int                            a;

  assign a = int'(addr_i);

  // next-state
  always_comb begin
    edge_d = edge_q;
    pol_d  = pol_q;
    filt_d = filt_q;
    sel_d  = sel_q;
    if (wr_i && a == A_MODE) begin
      edge_d = wdata_i[NUM_CH-1:0];
      pol_d  = wdata_i[POL_SHIFT +: NUM_CH];
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (wr_i && a == A_FILT)
        filt_d[ch] = wdata_i[ch*FILT_W +: FILT_W];
      if (wr_i && a == A_SEL0 + ch / SEL_PER_WORD)
        sel_d[ch] = wdata_i[(ch % SEL_PER_WORD)*SEL_W +: SEL_W];
    end
  end

  // register, clock enable = write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      pol_q  <= '0;
      filt_q <= '0;
      sel_q  <= '0;
    end else if (wr_i) begin
      edge_q <= edge_d;
      pol_q  <= pol_d;
      filt_q <= filt_d;
      sel_q  <= sel_d;
    end
  end

  // read path
  always_comb begin
    rdata_o = '0;
    if (a == A_MODE) begin
      rdata_o[NUM_CH-1:0]          = edge_q;
      rdata_o[POL_SHIFT +: NUM_CH] = pol_q;
    end
    if (a == A_STAT)
      rdata_o[NUM_CH-1:0] = pend_i;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (a == A_FILT)
        rdata_o[ch*FILT_W +: FILT_W] = filt_q[ch];
      if (a == A_SEL0 + ch / SEL_PER_WORD)
        rdata_o[(ch % SEL_PER_WORD)*SEL_W +: SEL_W] = sel_q[ch];
    end
  end

  assign clr_o  = (wr_i && a == A_STAT) ? wdata_i[NUM_CH-1:0] : '0;
  assign edge_o = edge_q;
  assign pol_o  = pol_q;
  assign filt_o = filt_q;
  assign sel_o  = sel_q;

  // R2: a mode write lands in the sense field on the next clock
  assert_pol_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && a == A_MODE) |=> pol_q == $past(wdata_i[POL_SHIFT +: NUM_CH]));

  // R8: a status write never alters configuration
  assert_stat_write_keeps_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && a == A_STAT) |=> ($stable(edge_q) && $stable(sel_q) && $stable(filt_q)));
endmodule

// File: rtl/gpio_irq_channel.sv
module gpio_irq_channel #(
  parameter int NUM_PINS = 256,
  parameter int SEL_W    = 8,
  parameter int FILT_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                tick_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                edge_mode_i,
  input  logic                pol_i,
  input  logic [FILT_W-1:0]   filt_cfg_i,
  input  logic                clr_i,
  output logic                irq_o,
  output logic                pend_o
);
  logic              raw;
  logic              filt_q, filt_d, prev_q, pend_q, pend_d, lvl_q, lvl_d;
  logic [FILT_W-1:0] cnt_q, cnt_d;
  logic [FILT_W:0]   cnt_inc;
  logic              rise, fall, hit;

  assign raw     = pins_i[sel_i];
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  // glitch filter next-state
  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (filt_cfg_i == '0) begin
      filt_d = raw;
      cnt_d  = '0;
    end else if (tick_i) begin
      if (raw == filt_q) begin
        cnt_d = '0;
      end else if (cnt_inc >= {1'b0, filt_cfg_i}) begin
        filt_d = raw;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc[FILT_W-1:0];
      end
    end
  end

  assign rise   = filt_q & ~prev_q;
  assign fall   = ~filt_q & prev_q;
  assign hit    = edge_mode_i & (pol_i ? fall : rise);
  assign pend_d = hit | (pend_q & ~clr_i);
  assign lvl_d  = filt_q ^ pol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
      prev_q <= filt_q;
      pend_q <= pend_d;
      lvl_q  <= lvl_d;
    end
  end

  assign irq_o  = edge_mode_i ? pend_q : lvl_q;
  assign pend_o = pend_q;

  // R10: bypass copies the selected pin every clock
  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_cfg_i == '0) |=> filt_q == $past(raw));

  // R9: with filtering on, the filtered value moves only on a sample tick
  assert_filter_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_cfg_i != '0 && !tick_i) |=> $stable(filt_q));

  // R6: a pending event persists until cleared
  assert_pending_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);

  // R8: a clear without a coincident edge drops the event
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !pend_q);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router import gpio_irq_pkg::*; #(
  parameter int NUM_PINS   = 256,
  parameter int NUM_CH     = 8,
  parameter int SAMPLE_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);
  localparam int SEL_W = $clog2(NUM_PINS);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [NUM_PINS-1:0]           pins_s;
  logic [NUM_CH-1:0]             edge_m, pol, clr, pend;
  logic [NUM_CH-1:0][FILT_W-1:0] filt_cfg;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel;
  logic [DIV_W-1:0]              div_q, div_d;
  logic                          tick;

  // sample tick divider
  assign tick  = (div_q == DIV_W'(SAMPLE_DIV - 1));
  assign div_d = tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  gpio_irq_sync #(.W(NUM_PINS)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  gpio_irq_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .pend_i  (pend),
    .edge_o  (edge_m),
    .pol_o   (pol),
    .filt_o  (filt_cfg),
    .sel_o   (sel),
    .clr_o   (clr)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gpio_irq_channel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .FILT_W(FILT_W)) i_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .pins_i      (pins_s),
      .tick_i      (tick),
      .sel_i       (sel[ch]),
      .edge_mode_i (edge_m[ch]),
      .pol_i       (pol[ch]),
      .filt_cfg_i  (filt_cfg[ch]),
      .clr_i       (clr[ch]),
      .irq_o       (irq_o[ch]),
      .pend_o      (pend[ch])
    );
  end

  // R1: lines are quiet in the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) $rose(rst_n) |-> irq_o == '0);
endmodule

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;
  import gpio_irq_pkg::*;
  localparam int NP  = 256;
  localparam int NC  = 8;
  localparam int DIV = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NP-1:0]   pins;
  logic            reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [REG_W-1:0]  reg_wdata;
  logic [REG_W-1:0]  reg_rdata;
  logic [NC-1:0]     irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_irq_router #(.NUM_PINS(NP), .NUM_CH(NC), .SAMPLE_DIV(DIV)) i_gpio_irq_router (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  function automatic int pin_of(int ch);
    return (ch * 37 + 11) % 256;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [31:0] data);
    reg_wr    = 1'b1;
    reg_addr  = ADDR_W'(addr);
    reg_wdata = data;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    reg_addr = ADDR_W'(addr);
    #1;
    data = reg_rdata;
  endtask

  task automatic rd_chk(int addr, logic [31:0] exp, string req);
    logic [31:0] v;
    rd(addr, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic set_sel_all();
    logic [31:0] w0, w1;
    w0 = 0; w1 = 0;
    for (int c = 0; c < 4; c++) begin
      w0 |= 32'(pin_of(c))     << (8 * c);
      w1 |= 32'(pin_of(c + 4)) << (8 * c);
    end
    wr(2, w0);
    wr(3, w1);
  endtask

  function automatic logic [NP-1:0] pins_of(logic [NC-1:0] m);
    logic [NP-1:0] p = '0;
    for (int c = 0; c < NC; c++) if (m[c]) p[pin_of(c)] = 1'b1;
    return p;
  endfunction

  initial begin
    int unsigned wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=finish", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] mask;
    rst_n = 1'b0; pins = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(3);
    // R1: reset state
    chk(irq == '0, "R1 irq", 32'(irq), 0);
    for (int a = 0; a < 5; a++) rd_chk(a, 0, "R1 reg");
    rst_n = 1'b1;
    step(2);
    chk(irq == '0, "R1 irq after release", 32'(irq), 0);

    // R2: readback and field placement
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h00FF_00FF, "R2 mode word");
    wr(1, 32'h1234_5678);
    rd_chk(1, 32'h1234_5678, "R2 filter word");
    wr(2, 32'hA1B2_C3D4);
    rd_chk(2, 32'hA1B2_C3D4, "R2 sel word 2");
    wr(3, 32'h0506_0708);
    rd_chk(3, 32'h0506_0708, "R2 sel word 3");
    rd_chk(2, 32'hA1B2_C3D4, "R2 sel word 2 kept");
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);

    // R3: every selector value on channel 0, level mode, sense 0
    for (int p = 0; p < NP; p++) begin
      wr(2, 32'(p));
      pins = '0; pins[p] = 1'b1;
      step(5);
      chk(irq[0] == 1'b1, $sformatf("R3 pin %0d high", p), 32'(irq[0]), 1);
      pins = ~pins;
      step(5);
      chk(irq[0] == 1'b0, $sformatf("R3 pin %0d others", p), 32'(irq[0]), 0);
    end

    // R11: independent channels
    set_sel_all();
    pins = '0;
    step(5);
    for (int c = 0; c < NC; c++) begin
      pins = pins_of(NC'(1) << c);
      step(5);
      chk(irq == (NC'(1) << c), $sformatf("R11 ch %0d", c), 32'(irq), 32'(1) << c);
    end

    // R4: latency in level mode
    pins = '0;
    step(5);
    pins = pins_of(NC'(1));
    step(3);
    chk(irq[0] == 1'b0, "R4 not before 4th edge", 32'(irq[0]), 0);
    step(1);
    chk(irq[0] == 1'b1, "R4 at 4th edge", 32'(irq[0]), 1);
    pins = '0;
    step(4);
    chk(irq[0] == 1'b0, "R4 follows low", 32'(irq[0]), 0);

    // R5: inverted sense level mode
    wr(0, 32'h00FF_0000);
    step(5);
    chk(irq == '1, "R5 low pins", 32'(irq), 32'hFF);
    pins = pins_of('1);
    step(5);
    chk(irq == '0, "R5 high pins", 32'(irq), 0);

    // R6: rising edge, sticky
    pins = '0;
    wr(0, 32'h0000_00FF);
    step(5);
    wr(4, 32'hFF);
    chk(irq == '0, "R6 cleared start", 32'(irq), 0);
    mask = '0;
    for (int c = 0; c < NC; c++) begin
      pins = pins_of(NC'(1) << c);
      step(5);
      mask[c] = 1'b1;
      chk(irq == mask, $sformatf("R6 rise ch %0d", c), 32'(irq), 32'(mask));
    end
    pins = '0;
    step(5);
    chk(irq == '1, "R6 stays after fall", 32'(irq), 32'hFF);
    rd_chk(4, 32'hFF, "R8 status read");

    // R8: write-one-to-clear
    wr(4, 32'h55);
    chk(irq == 8'hAA, "R8 clear 0x55", 32'(irq), 32'hAA);
    wr(4, 32'h00);
    step(2);
    chk(irq == 8'hAA, "R8 zero write keeps", 32'(irq), 32'hAA);
    rd_chk(4, 32'hAA, "R8 status after partial clear");
    wr(4, 32'hAA);
    chk(irq == '0, "R8 clear rest", 32'(irq), 0);

    // R7: falling edge with inverted sense
    pins = pins_of('1);
    wr(0, 32'h00FF_00FF);
    step(5);
    wr(4, 32'hFF);
    chk(irq == '0, "R7 start", 32'(irq), 0);
    pins = '0;
    step(5);
    chk(irq == '1, "R7 falling sets", 32'(irq), 32'hFF);
    wr(4, 32'hFF);
    pins = pins_of('1);
    step(5);
    chk(irq == '0, "R7 rising ignored", 32'(irq), 0);

    // R9: filter lengths 2..7 on channel 0, edge mode, sense 0
    pins = '0;
    wr(0, 32'h0000_0001);
    for (int k = 2; k <= 7; k++) begin
      wr(1, 32'(k));
      step((k + 1) * DIV + 6);
      wr(4, 32'hFF);
      chk(irq[0] == 1'b0, $sformatf("R9 k=%0d idle", k), 32'(irq[0]), 0);
      pins = pins_of(NC'(1));
      step((k - 1) * DIV);
      pins = '0;
      step((k + 1) * DIV + 6);
      chk(irq[0] == 1'b0, $sformatf("R9 k=%0d short pulse", k), 32'(irq[0]), 0);
      pins = pins_of(NC'(1));
      step((k + 1) * DIV + 6);
      chk(irq[0] == 1'b1, $sformatf("R9 k=%0d long pulse", k), 32'(irq[0]), 1);
      pins = '0;
    end

    // R10: bypass lets a one-clock pulse through
    wr(1, 0);
    step(5);
    wr(4, 32'hFF);
    chk(irq[0] == 1'b0, "R10 idle", 32'(irq[0]), 0);
    pins = pins_of(NC'(1));
    step(1);
    pins = '0;
    step(5);
    chk(irq[0] == 1'b1, "R10 one-clock pulse", 32'(irq[0]), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule